// File: doc/BRIEF.md
# NAND Command Sequencer

This block turns one host-written command word into the raw byte-level traffic of a NAND flash bus. The host sets up the address registers and a command-set register, then writes a packed command word. Each phase of a NAND operation has its own enable bit in that word, and the block runs the enabled phases in a fixed order: first opcode, address bytes, second opcode, ready wait, and a single data byte. Command and address bytes are qualified by the latch outputs and clocked by the write strobe. The flash's ready/busy line is synchronised and sampled. When the sequence ends, a sticky completion flag is set, and the host clears it by writing a one.

The host side is a plain word-indexed register port with a write strobe and a combinational read. Word 0 is control: bit 0 enables the block and bit 1 starts a soft reset. Word 1 is status: bit 1 is done and bit 4 is busy. Word 2 holds address low and word 3 address high. Word 4 takes the command word. Word 5 is the command set, whose bits [7:0] give the second opcode. Word 6 is the data byte. Strobe low and high times, the ready-fall delay and the soft-reset length are parameters counted in clock cycles.

Top module: `nand_cmd_seq`

## Requirements
- R1: A command word runs only the phases whose bits are set, always in this order: first opcode (bit 22, byte taken from bits [7:0]), address (bit 19), second opcode (bit 24), ready wait (bit 23), data byte (bit 21).
- R2: The address phase sends the number of bytes in bits [18:16] plus one. Bytes go least significant first from the 64-bit value {address high, address low}, so a page number in low bits [31:16] and high bits [7:0] follows two zero column bytes.
- R3: The second opcode is the byte in bits [7:0] of the command-set register (word 5), not a field of the command word.
- R4: The command latch is high only during opcode bytes and the address latch only during address bytes. The two are never high together. The I/O output enable is high for opcode, address and write-data bytes. Every write strobe falls with the output enable high.
- R5: Each strobe pulse stays low for exactly T_LOW cycles and then high for T_HIGH cycles before the next byte starts.
- R6: With the ready wait enabled, the block first waits T_WB cycles and then waits until the synchronised ready input is high. Busy stays set and done stays clear while ready is low.
- R7: Status bit 1 (done) is set when a sequence ends. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R8: Status bit 4 (busy) is high while a sequence runs. A command word written while busy is ignored and produces no bus activity.
- R9: A sequence starts only when control bit 0 is set and command-word bits [31:30] are 00. Other type codes, or a cleared enable, leave the bus idle.
- R10: Writing 1 to control bit 1 aborts any sequence and clears done. Bit 1 reads back high for RST_CYCLES cycles and then clears itself. Control bit 0 keeps the written value.
- R11: In the data phase, command-word bit 20 set drives the data register's low byte with a write strobe. With bit 20 clear, the block pulses the read strobe and captures the I/O input into data register bits [7:0] at the end of the low time.
- R12: After reset both strobes are high, both latches and the output enable are low, and control and status read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register word index |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data for the indexed register |
| cmd_latch_o | output | 1 | Command latch enable to flash |
| addr_latch_o | output | 1 | Address latch enable to flash |
| wr_strobe_no | output | 1 | Write strobe, active low |
| rd_strobe_no | output | 1 | Read strobe, active low |
| io_o | output | 8 | Flash I/O output byte |
| io_oe_o | output | 1 | Flash I/O output enable |
| io_i | input | 8 | Flash I/O input byte |
| ready_i | input | 1 | Flash ready (high) / busy (low) |

## Verification
The bench checks the largest address count of eight bytes and the smallest of one byte. A design that stored the count without the minus-one bias would send one byte too many or too few. It issues a second opcode with no first opcode, to catch a sequencer that takes that byte from the command word or always starts with the first phase. It holds ready low and writes a competing command word during the wait. A design that restarted or queued the second word would show an extra opcode on the bus. It then writes zero to the status register, aborts a running sequence with the soft reset, and reads a data byte back. These cover a flag cleared by any write, an abort that leaves the sequencer stuck, and a read strobe that samples outside its low window.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // command word fields
  localparam int CW_ADDR      = 19;
  localparam int CW_DIR       = 20;
  localparam int CW_DATA      = 21;
  localparam int CW_CMD1      = 22;
  localparam int CW_WAIT      = 23;
  localparam int CW_CMD2      = 24;
  localparam int CW_NADDR_LSB = 16;
  localparam int CW_NADDR_W   = 3;
  localparam logic [1:0] CW_TYPE_RAW = 2'b00;

  // register word indices
  localparam logic [2:0] RI_CTRL    = 3'd0;
  localparam logic [2:0] RI_STAT    = 3'd1;
  localparam logic [2:0] RI_ADDR_LO = 3'd2;
  localparam logic [2:0] RI_ADDR_HI = 3'd3;
  localparam logic [2:0] RI_CMD     = 3'd4;
  localparam logic [2:0] RI_RCMD    = 3'd5;
  localparam logic [2:0] RI_DATA    = 3'd6;

  localparam int ST_DONE = 1;
  localparam int ST_BUSY = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD1, PH_ADDR, PH_CMD2, PH_TWB, PH_RDY, PH_DATA, PH_DONE
  } phase_e;

  typedef struct packed {
    logic [7:0]            op1;
    logic [CW_NADDR_W-1:0] naddr_m1;
    logic                  cmd1;
    logic                  send_addr;
    logic                  cmd2;
    logic                  wait_rdy;
    logic                  data;
    logic                  dir_wr;
  } seq_cfg_t;

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        busy_i,
  input  logic        done_evt_i,
  input  logic        rd_vld_i,
  input  logic [7:0]  rd_byte_i,
  output logic        start_o,
  output seq_cfg_t    cfg_o,
  output logic [63:0] addr_o,
  output logic [7:0]  op2_o,
  output logic [7:0]  wdata_o,
  output logic        soft_rst_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic          ctrl_en_q;
  logic [RW-1:0] rst_cnt_q;
  logic          done_q;
  logic [31:0]   addr_lo_q, addr_hi_q;
  logic [23:0]   rcmd_q;
  logic [7:0]    data_q;

  logic wr_ctrl, wr_stat, wr_lo, wr_hi, wr_cmd, wr_rcmd, wr_data;
  assign wr_ctrl = reg_we_i && reg_addr_i == RI_CTRL;
  assign wr_stat = reg_we_i && reg_addr_i == RI_STAT;
  assign wr_lo   = reg_we_i && reg_addr_i == RI_ADDR_LO;
  assign wr_hi   = reg_we_i && reg_addr_i == RI_ADDR_HI;
  assign wr_cmd  = reg_we_i && reg_addr_i == RI_CMD;
  assign wr_rcmd = reg_we_i && reg_addr_i == RI_RCMD;
  assign wr_data = reg_we_i && reg_addr_i == RI_DATA;

  assign soft_rst_o = rst_cnt_q != '0;
  assign start_o = wr_cmd && reg_wdata_i[31:30] == CW_TYPE_RAW && ctrl_en_q
                   && !busy_i && !soft_rst_o;

  always_comb begin
    cfg_o.op1       = reg_wdata_i[7:0];
    cfg_o.naddr_m1  = reg_wdata_i[CW_NADDR_LSB +: CW_NADDR_W];
    cfg_o.cmd1      = reg_wdata_i[CW_CMD1];
    cfg_o.send_addr = reg_wdata_i[CW_ADDR];
    cfg_o.cmd2      = reg_wdata_i[CW_CMD2];
    cfg_o.wait_rdy  = reg_wdata_i[CW_WAIT];
    cfg_o.data      = reg_wdata_i[CW_DATA];
    cfg_o.dir_wr    = reg_wdata_i[CW_DIR];
  end

  assign addr_o  = {addr_hi_q, addr_lo_q};
  assign op2_o   = rcmd_q[7:0];
  assign wdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      rst_cnt_q <= '0;
      done_q    <= 1'b0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      rcmd_q    <= '0;
      data_q    <= '0;
    end else begin
      if (wr_ctrl) ctrl_en_q <= reg_wdata_i[0];
      if (wr_ctrl && reg_wdata_i[1]) rst_cnt_q <= RW'(RST_CYCLES);
      else if (soft_rst_o)           rst_cnt_q <= rst_cnt_q - 1'b1;
      if (soft_rst_o)                             done_q <= 1'b0;
      else if (done_evt_i)                        done_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_DONE])   done_q <= 1'b0;
      if (wr_lo)   addr_lo_q <= reg_wdata_i;
      if (wr_hi)   addr_hi_q <= reg_wdata_i;
      if (wr_rcmd) rcmd_q    <= reg_wdata_i[23:0];
      if (rd_vld_i)     data_q <= rd_byte_i;
      else if (wr_data) data_q <= reg_wdata_i[7:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RI_CTRL:    reg_rdata_o = {30'b0, soft_rst_o, ctrl_en_q};
      RI_STAT:    reg_rdata_o = {27'b0, busy_i, 2'b0, done_q, 1'b0};
      RI_ADDR_LO: reg_rdata_o = addr_lo_q;
      RI_ADDR_HI: reg_rdata_o = addr_hi_q;
      RI_RCMD:    reg_rdata_o = {8'b0, rcmd_q};
      RI_DATA:    reg_rdata_o = {24'b0, data_q};
      default:    reg_rdata_o = '0;
    endcase
  end

  AST_DONE_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[ST_DONE] && !done_evt_i) |=> !done_q); // R7

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int T_LOW  = 2,
  parameter int T_HIGH = 2,
  parameter int T_WB   = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        soft_rst_i,
  input  logic        start_i,
  input  seq_cfg_t    cfg_i,
  input  logic [63:0] addr_i,
  input  logic [7:0]  op2_i,
  input  logic [7:0]  wdata_i,
  input  logic        ready_i,
  output logic        busy_o,
  output logic        done_evt_o,
  output logic        rd_vld_o,
  output logic        cmd_latch_o,
  output logic        addr_latch_o,
  output logic        wr_strobe_no,
  output logic        rd_strobe_no,
  output logic [7:0]  io_o,
  output logic        io_oe_o
);
  localparam int TM1   = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int TMAX  = (TM1 > T_WB) ? TM1 : T_WB;
  localparam int CNT_W = $clog2(TMAX + 1);

  typedef struct packed {
    phase_e                ph;
    logic                  low;
    logic [CNT_W-1:0]      cnt;
    logic [CW_NADDR_W-1:0] idx;
  } st_t;

  st_t         st_q, st_d;
  seq_cfg_t    cfg_q;
  logic [63:0] addr_q;
  logic [7:0]  op2_q, wd_q;
  logic        rdy_s1_q, rdy_s2_q;

  // earliest enabled phase after p; later ifs override earlier ones
  function automatic phase_e next_ph(phase_e p, seq_cfg_t c);
    phase_e n = PH_DONE;
    if (p < PH_DATA && c.data)      n = PH_DATA;
    if (p < PH_TWB  && c.wait_rdy)  n = PH_TWB;
    if (p < PH_CMD2 && c.cmd2)      n = PH_CMD2;
    if (p < PH_ADDR && c.send_addr) n = PH_ADDR;
    if (p < PH_CMD1 && c.cmd1)      n = PH_CMD1;
    return n;
  endfunction

  function automatic st_t enter(phase_e t);
    st_t s;
    s.ph  = t;
    s.idx = '0;
    s.low = (t == PH_CMD1) || (t == PH_ADDR) || (t == PH_CMD2) || (t == PH_DATA);
    s.cnt = s.low ? CNT_W'(T_LOW - 1) : (t == PH_TWB) ? CNT_W'(T_WB - 1) : '0;
    return s;
  endfunction

  always_comb begin
    st_d = st_q;
    case (st_q.ph)
      PH_IDLE: if (start_i) st_d = enter(next_ph(PH_IDLE, cfg_i));
      PH_CMD1, PH_ADDR, PH_CMD2, PH_DATA: begin
        if (st_q.cnt != '0) begin
          st_d.cnt = st_q.cnt - 1'b1;
        end else if (st_q.low) begin
          st_d.low = 1'b0;
          st_d.cnt = CNT_W'(T_HIGH - 1);
        end else if (st_q.ph == PH_ADDR && st_q.idx != cfg_q.naddr_m1) begin
          st_d.idx = st_q.idx + 1'b1;
          st_d.low = 1'b1;
          st_d.cnt = CNT_W'(T_LOW - 1);
        end else begin
          st_d = enter(next_ph(st_q.ph, cfg_q));
        end
      end
      PH_TWB:  if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
               else st_d = enter(PH_RDY);
      PH_RDY:  if (rdy_s2_q) st_d = enter(next_ph(PH_RDY, cfg_q));
      default: st_d = enter(PH_IDLE);
    endcase
    if (soft_rst_i) st_d = enter(PH_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '{ph: PH_IDLE, low: 1'b0, cnt: '0, idx: '0};
      cfg_q    <= '0;
      addr_q   <= '0;
      op2_q    <= '0;
      wd_q     <= '0;
      rdy_s1_q <= 1'b0;
      rdy_s2_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rdy_s1_q <= ready_i;
      rdy_s2_q <= rdy_s1_q;
      if (st_q.ph == PH_IDLE && start_i) begin
        cfg_q  <= cfg_i;
        addr_q <= addr_i;
        op2_q  <= op2_i;
        wd_q   <= wdata_i;
      end
    end
  end

  logic is_cmd, is_addr, d_wr, d_rd;
  assign is_cmd  = st_q.ph == PH_CMD1 || st_q.ph == PH_CMD2;
  assign is_addr = st_q.ph == PH_ADDR;
  assign d_wr    = st_q.ph == PH_DATA && cfg_q.dir_wr;
  assign d_rd    = st_q.ph == PH_DATA && !cfg_q.dir_wr;

  assign busy_o       = st_q.ph != PH_IDLE;
  assign done_evt_o   = st_q.ph == PH_DONE;
  assign cmd_latch_o  = is_cmd;
  assign addr_latch_o = is_addr;
  assign io_oe_o      = is_cmd || is_addr || d_wr;
  assign wr_strobe_no = !(st_q.low && io_oe_o);
  assign rd_strobe_no = !(st_q.low && d_rd);
  assign rd_vld_o     = d_rd && st_q.low && st_q.cnt == '0;

  always_comb begin
    case (st_q.ph)
      PH_CMD1: io_o = cfg_q.op1;
      PH_ADDR: io_o = addr_q[{st_q.idx, 3'b000} +: 8];
      PH_CMD2: io_o = op2_q;
      PH_DATA: io_o = d_wr ? wd_q : 8'h00;
      default: io_o = 8'h00;
    endcase
  end

  // strobe low-time monitor
  logic             strobe_lo;
  logic [CNT_W:0]   low_run_q;
  assign strobe_lo = !wr_strobe_no || !rd_strobe_no;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_run_q <= '0;
    else if (!strobe_lo)               low_run_q <= '0;
    else if (low_run_q != '1)          low_run_q <= low_run_q + 1'b1;
  end

  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_lo && $past(strobe_lo) && !$past(soft_rst_i))
      |-> low_run_q == (CNT_W+1)'(T_LOW)); // R5

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> st_q.ph == PH_IDLE); // R8

  AST_READY_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q.ph) == PH_RDY && st_q.ph != PH_RDY && !$past(soft_rst_i))
      |-> $past(rdy_s2_q)); // R6

  AST_ADDR_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q.ph) == PH_ADDR && st_q.ph != PH_ADDR && !$past(soft_rst_i))
      |-> $past(st_q.idx) == $past(cfg_q.naddr_m1)); // R2

  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_no |-> io_oe_o && !(cmd_latch_o && addr_latch_o)); // R4

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2,
  parameter int T_WB       = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        cmd_latch_o,
  output logic        addr_latch_o,
  output logic        wr_strobe_no,
  output logic        rd_strobe_no,
  output logic [7:0]  io_o,
  output logic        io_oe_o,
  input  logic [7:0]  io_i,
  input  logic        ready_i
);
  logic        busy, done_evt, rd_vld, start, soft_rst;
  seq_cfg_t    cfg;
  logic [63:0] addr;
  logic [7:0]  op2, wdata;

  nand_seq_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .done_evt_i(done_evt), .rd_vld_i(rd_vld), .rd_byte_i(io_i),
    .start_o(start), .cfg_o(cfg), .addr_o(addr), .op2_o(op2),
    .wdata_o(wdata), .soft_rst_o(soft_rst)
  );

  nand_seq_fsm #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_WB(T_WB)) u_fsm (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst), .start_i(start), .cfg_i(cfg),
    .addr_i(addr), .op2_i(op2), .wdata_i(wdata), .ready_i,
    .busy_o(busy), .done_evt_o(done_evt), .rd_vld_o(rd_vld),
    .cmd_latch_o, .addr_latch_o, .wr_strobe_no, .rd_strobe_no, .io_o, .io_oe_o
  );

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_LOW = 2, T_HIGH = 2, T_WB = 3, RST_CYCLES = 4;
  localparam logic [2:0] A_CTRL = 0, A_STAT = 1, A_LO = 2, A_HI = 3,
                         A_CMD = 4, A_RCMD = 5, A_DATA = 6;
  localparam int NV = 6;
  // {command word, address low, address high}
  localparam logic [95:0] VECS [NV] = '{
    {32'h01D4_0000, 32'h1234_0000, 32'h0000_0056},
    {32'h00C0_00FF, 32'h0000_0000, 32'h0000_0000},
    {32'h0008_0000, 32'h0000_00A5, 32'h0000_0000},
    {32'h004F_0090, 32'h89AB_CDEF, 32'h0123_4567},
    {32'h0079_0080, 32'h0000_BEEF, 32'h0000_0000},
    {32'h0100_0000, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 0, rst_n = 0, we = 0, ready = 1;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0]  io_in = 8'hC3, io_out;
  logic        cle, ale, we_n, re_n, oe;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_seq #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_WB(T_WB), .RST_CYCLES(RST_CYCLES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmd_latch_o(cle),
    .addr_latch_o(ale), .wr_strobe_no(we_n), .rd_strobe_no(re_n),
    .io_o(io_out), .io_oe_o(oe), .io_i(io_in), .ready_i(ready)
  );

  // bus monitor, sampled away from the active edge
  logic [9:0] log_mem [256];
  int n_log = 0, n_rd = 0, lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
  bit we_prev = 1, re_prev = 1, oe_bad = 0;
  always @(negedge clk) begin
    if (!we_n) begin
      if (we_prev) begin
        log_mem[n_log[7:0]] = {cle, ale, io_out};
        n_log++;
        if (!oe || (cle && ale)) oe_bad = 1;
        last_hi = hi_run;
        lo_run = 1;
      end else lo_run++;
    end else begin
      if (!we_prev) begin last_lo = lo_run; hi_run = 1; end
      else hi_run++;
    end
    if (!re_n && re_prev) n_rd++;
    we_prev = we_n;
    re_prev = re_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit idle = 0;
    for (int i = 0; i < 500 && !idle; i++) begin
      rd(A_STAT, s);
      idle = !s[4];
    end
    chk(idle, req, {31'b0, idle}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, cw;
    logic [63:0] av;
    logic [9:0]  exp_log [16];
    int en, base;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: reset state
    rd(A_CTRL, r); chk(r == 0, "R12 ctrl", r, 0);
    rd(A_STAT, r); chk(r == 0, "R12 stat", r, 0);
    chk({we_n, re_n, cle, ale, oe} == 5'b11000, "R12 pins",
        {27'b0, we_n, re_n, cle, ale, oe}, 32'h18);

    // R9: disabled block ignores commands
    base = n_log;
    wr(A_CMD, 32'h00C0_00FF);
    repeat (10) @(negedge clk);
    rd(A_STAT, r);
    chk(r == 0 && n_log == base, "R9 disabled", r, 0);

    wr(A_CTRL, 32'h1);
    wr(A_RCMD, 32'h00E0_0530);
    wr(A_DATA, 32'h5A);

    // R9: non-raw type ignored
    wr(A_CMD, 32'h80C0_00FF);
    repeat (10) @(negedge clk);
    rd(A_STAT, r);
    chk(r == 0 && n_log == base, "R9 page type", n_log - base, 0);

    // vector walk: R1 R2 R3 R11(write)
    for (int v = 0; v < NV; v++) begin
      cw = VECS[v][95:64];
      av = {VECS[v][31:0], VECS[v][63:32]};
      en = 0;
      if (cw[22]) begin exp_log[en] = {2'b10, cw[7:0]}; en++; end
      if (cw[19])
        for (int i = 0; i <= int'(cw[18:16]); i++) begin
          exp_log[en] = {2'b01, av[8*i +: 8]}; en++;
        end
      if (cw[24]) begin exp_log[en] = {2'b10, 8'h30}; en++; end
      if (cw[21] && cw[20]) begin exp_log[en] = {2'b00, 8'h5A}; en++; end
      base = n_log;
      wr(A_LO, VECS[v][63:32]);
      wr(A_HI, VECS[v][31:0]);
      wr(A_CMD, cw);
      wait_idle("R1 completes");
      chk(n_log - base == en, "R1 byte count", n_log - base, en);
      for (int i = 0; i < en; i++)
        chk(log_mem[(base + i) % 256] == exp_log[i], "R1/R2/R3 byte",
            {22'b0, log_mem[(base + i) % 256]}, {22'b0, exp_log[i]});
      rd(A_STAT, r); chk(r[1] == 1'b1, "R7 done set", r, 32'h2);
      if (v == 0) begin
        chk(last_lo == T_LOW, "R5 low time", last_lo, T_LOW);
        chk(last_hi == T_HIGH, "R5 high time", last_hi, T_HIGH);
      end
      wr(A_STAT, 32'h2);
    end
    chk(!oe_bad, "R4 latch/oe on strobes", {31'b0, oe_bad}, 0);
    chk({cle, ale, oe} == 3'b000, "R4 idle latches", {29'b0, cle, ale, oe}, 0);

    // R6, R8: ready wait and busy ignore
    ready = 0;
    base = n_log;
    wr(A_CMD, 32'h00C0_0070);
    repeat (20) @(negedge clk);
    rd(A_STAT, r);
    chk(r[4] == 1'b1 && r[1] == 1'b0, "R6 waits while busy line low", r, 32'h10);
    wr(A_CMD, 32'h0040_0011);
    repeat (5) @(negedge clk);
    ready = 1;
    wait_idle("R6 completes after ready");
    chk(n_log - base == 1 && log_mem[base % 256] == {2'b10, 8'h70},
        "R8 busy write ignored", n_log - base, 1);
    rd(A_STAT, r); chk(r == 32'h2, "R6 done after ready", r, 32'h2);

    // R7: W1C semantics
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); chk(r[1] == 1'b1, "R7 write zero keeps", r, 32'h2);
    wr(A_STAT, 32'h2);
    rd(A_STAT, r); chk(r[1] == 1'b0, "R7 write one clears", r, 0);

    // R11: data read
    base = n_rd;
    en = n_log;
    wr(A_CMD, 32'h0020_0000);
    wait_idle("R11 completes");
    rd(A_DATA, r); chk(r == 32'hC3, "R11 captured byte", r, 32'hC3);
    chk(n_rd - base == 1 && n_log == en, "R11 one read strobe", n_rd - base, 1);

    // R10: soft reset aborts and self-clears
    ready = 0;
    wr(A_CMD, 32'h00C0_0070);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, r); chk(r == 32'h3, "R10 reset bit visible", r, 32'h3);
    repeat (RST_CYCLES + 4) @(negedge clk);
    rd(A_CTRL, r); chk(r == 32'h1, "R10 reset bit self-clears", r, 32'h1);
    rd(A_STAT, r); chk(r == 32'h0, "R10 aborted and done clear", r, 0);
    ready = 1;
    base = n_log;
    wr(A_CMD, 32'h0040_0011);
    wait_idle("R10 usable after reset");
    chk(n_log - base == 1 && log_mem[base % 256] == {2'b10, 8'h11},
        "R10 new command runs", n_log - base, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule